// File: doc/BRIEF.md
# Dual-Issue Warp Scheduler

This block decides, every clock cycle, which warps of a multithreaded SIMT core get to issue. A warp is a group of 32 threads that follow one instruction stream and execute each instruction together. The scheduler keeps a small amount of state for each slot in a fixed pool. A slot is either live or free, and a live warp is either parked or ready. A parked warp is waiting on a memory access or on some other event that has not yet completed. Each cycle up to two different ready warps are chosen and presented on two issue ports. Moving from one warp to another costs no cycles.

A warp enters a free slot through the launch input. It keeps that slot, and is never pre-empted, until the retire input frees it. The decode stage supplies one flag per slot, `next_long`, which says that the warp's next instruction is long-latency. If a warp is picked while its flag is high, the warp parks. A tagged wake input clears the park when the operation completes. Each port has its own rotating pointer, so no ready warp is starved.

Top module: `warp_dual_issue`

## Requirements
- R1: While `rst` is high, and on the first edge after it, both issue valids are low and `idle` is high. The port A pointer resets to slot 0 and the port B pointer resets to slot NUM_WARPS/2.
- R2: A launch to a free slot makes that slot live and ready at the next edge. Its first issue can appear no earlier than the second edge after the launch edge.
- R3: A warp can be picked only if it is live, not parked, and not named by `retire_en`/`retire_id` in that same cycle.
- R4: Port A picks the first ready warp at or above its pointer, wrapping from NUM_WARPS-1 to 0. After a pick, the pointer moves to the slot just past the picked warp.
- R5: Port B picks the first ready warp at or above its own pointer, leaving out port A's pick. Port B issues only when port A issues, and never in the same cycle names the same warp as port A. When exactly one warp is ready, only port A issues.
- R6: A warp that is picked while `next_long[w]` is high parks. From the next cycle it is not picked again until it is woken.
- R7: `wake_en` with `wake_id` = w clears the park of warp w. If the same warp is parked by a pick in that same cycle, the park wins. A wake to a warp that is not parked has no effect.
- R8: `retire_en` frees a live slot and also clears its park. A retire to a free slot has no effect. A launch to a live slot has no effect, and in particular does not clear a park.
- R9: `idle` is high exactly when no slot is live, and it follows the slot state one edge after a launch or retire.
- R10: If N warps stay ready, every one of them issues on some port within NUM_WARPS cycles.
- R11: Both issue ports are registered. A selection made from the state in one cycle appears on the ports after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_en | input | 1 | Launch a warp into a slot |
| launch_id | input | IW | Slot for the launch |
| retire_en | input | 1 | Retire (exit) a warp |
| retire_id | input | IW | Slot for the retire |
| wake_en | input | 1 | Completion of an outstanding operation |
| wake_id | input | IW | Tag: slot whose park is cleared |
| next_long | input | NUM_WARPS | Per-slot flag: the next instruction is long-latency |
| issue_a_vld | output | 1 | Port A issues this cycle |
| issue_a_id | output | IW | Warp on port A |
| issue_b_vld | output | 1 | Port B issues this cycle |
| issue_b_id | output | IW | Warp on port B |
| idle | output | 1 | No slot is live |

## Verification
The assertions assume that every slot tag presented on the launch, retire and wake inputs is below NUM_WARPS. The launch-to-not-idle property also assumes that a launch and a retire of the same slot do not arrive in the same cycle. The stimulus uses only tags of live or deliberately free slots inside the pool, and never pairs a launch with a retire of the same slot. The park property relies on `next_long` being sampled on the same edge as the pick. For that reason the bench changes `next_long` only on the falling edge.

// File: rtl/ws_pkg.sv
package ws_pkg;

  // Per-slot scheduling state
  typedef struct packed {
    logic live;    // slot holds a launched warp
    logic parked;  // warp waits on an outstanding operation
  } slot_t;

endpackage

// File: rtl/wsched_slot.sv
module wsched_slot
  import ws_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic do_launch,
  input  logic do_retire,
  input  logic do_park,
  input  logic do_wake,
  output logic live,
  output logic parked
);

  slot_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else if (do_launch && !st_q.live) begin
      st_q.live   <= 1'b1;
      st_q.parked <= 1'b0;
    end else if (do_retire && st_q.live) begin
      st_q <= '0;
    end else if (do_park) begin
      st_q.parked <= 1'b1;        // park wins over a simultaneous wake
    end else if (do_wake) begin
      st_q.parked <= 1'b0;
    end
  end

  assign live   = st_q.live;
  assign parked = st_q.parked;

endmodule

// File: rtl/wsched_rr.sv
module wsched_rr #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] base,
  output logic          found,
  output logic [IW-1:0] idx
);

  localparam int SW = IW + 1;

  logic [SW-1:0] s;

  // first request at or above base, wrapping modulo N
  always_comb begin
    found = 1'b0;
    idx   = '0;
    s     = '0;
    for (int i = 0; i < N; i++) begin
      s = {1'b0, base} + SW'(i);
      if (s >= SW'(N)) s = s - SW'(N);
      if (!found && req[s[IW-1:0]]) begin
        found = 1'b1;
        idx   = s[IW-1:0];
      end
    end
  end

endmodule

// File: rtl/warp_dual_issue.sv
module warp_dual_issue #(
  parameter  int NUM_WARPS = 16,
  localparam int IW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 launch_en,
  input  logic [IW-1:0]        launch_id,
  input  logic                 retire_en,
  input  logic [IW-1:0]        retire_id,
  input  logic                 wake_en,
  input  logic [IW-1:0]        wake_id,
  input  logic [NUM_WARPS-1:0] next_long,
  output logic                 issue_a_vld,
  output logic [IW-1:0]        issue_a_id,
  output logic                 issue_b_vld,
  output logic [IW-1:0]        issue_b_id,
  output logic                 idle
);

  localparam logic [IW-1:0] PTR_B_INIT = IW'(NUM_WARPS / 2);
  localparam logic [IW-1:0] LAST_SLOT  = IW'(NUM_WARPS - 1);

  logic [NUM_WARPS-1:0] live_v, parked_v, elig, oh_a, oh_b, req_b;
  logic [IW-1:0]        ptr_a, ptr_b, pick_a, pick_b;
  logic                 got_a, got_b;

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] x);
    return (x == LAST_SLOT) ? '0 : x + 1'b1;
  endfunction

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_slot
    localparam logic [IW-1:0] GID = IW'(g);
    logic hit_l, hit_r, hit_w, hit_p;

    assign hit_l   = launch_en && (launch_id == GID);
    assign hit_r   = retire_en && (retire_id == GID);
    assign hit_w   = wake_en && (wake_id == GID);
    assign elig[g] = live_v[g] && !parked_v[g] && !hit_r;
    assign oh_a[g] = got_a && (pick_a == GID);
    assign oh_b[g] = got_b && (pick_b == GID);
    assign hit_p   = next_long[g] && (oh_a[g] || oh_b[g]);

    wsched_slot u_slot (
      .clk       (clk),
      .rst       (rst),
      .do_launch (hit_l),
      .do_retire (hit_r),
      .do_park   (hit_p),
      .do_wake   (hit_w),
      .live      (live_v[g]),
      .parked    (parked_v[g])
    );
  end

  wsched_rr #(.N(NUM_WARPS), .IW(IW)) u_pick_a (
    .req   (elig),
    .base  (ptr_a),
    .found (got_a),
    .idx   (pick_a)
  );

  assign req_b = got_a ? (elig & ~oh_a) : '0;

  wsched_rr #(.N(NUM_WARPS), .IW(IW)) u_pick_b (
    .req   (req_b),
    .base  (ptr_b),
    .found (got_b),
    .idx   (pick_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_a       <= '0;
      ptr_b       <= PTR_B_INIT;
      issue_a_vld <= 1'b0;
      issue_a_id  <= '0;
      issue_b_vld <= 1'b0;
      issue_b_id  <= '0;
    end else begin
      issue_a_vld <= got_a;
      issue_a_id  <= pick_a;
      issue_b_vld <= got_b;
      issue_b_id  <= pick_b;
      if (got_a) ptr_a <= wrap_inc(pick_a);
      if (got_b) ptr_b <= wrap_inc(pick_b);
    end
  end

  assign idle = ~|live_v;

endmodule

// File: rtl/wsched_chk.sv
module wsched_chk #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          launch_en,
  input logic [IW-1:0] launch_id,
  input logic          retire_en,
  input logic [IW-1:0] retire_id,
  input logic [N-1:0]  next_long,
  input logic          issue_a_vld,
  input logic [IW-1:0] issue_a_id,
  input logic          issue_b_vld,
  input logic [IW-1:0] issue_b_id,
  input logic          idle,
  input logic [N-1:0]  live_v,
  input logic [N-1:0]  parked_v
);

  logic [N-1:0] ready_q, long_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= '0;
      long_q  <= '0;
    end else begin
      ready_q <= live_v & ~parked_v;
      long_q  <= next_long;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (idle && !issue_a_vld && !issue_b_vld));

  // R5
  ports_distinct_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_a_vld && issue_b_vld) |-> (issue_a_id != issue_b_id));

  // R5
  b_needs_a_chk: assert property (@(posedge clk) disable iff (rst)
    issue_b_vld |-> issue_a_vld);

  // R3
  a_was_ready_chk: assert property (@(posedge clk) disable iff (rst)
    issue_a_vld |-> ready_q[issue_a_id]);

  // R3
  b_was_ready_chk: assert property (@(posedge clk) disable iff (rst)
    issue_b_vld |-> ready_q[issue_b_id]);

  // R6
  park_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_a_vld && long_q[issue_a_id]) |=>
      (!(issue_a_vld && issue_a_id == $past(issue_a_id)) &&
       !(issue_b_vld && issue_b_id == $past(issue_a_id))));

  // R9
  launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (launch_en && !(retire_en && retire_id == launch_id)) |=> !idle);

endmodule

bind warp_dual_issue wsched_chk #(.N(NUM_WARPS), .IW(IW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .launch_en   (launch_en),
  .launch_id   (launch_id),
  .retire_en   (retire_en),
  .retire_id   (retire_id),
  .next_long   (next_long),
  .issue_a_vld (issue_a_vld),
  .issue_a_id  (issue_a_id),
  .issue_b_vld (issue_b_vld),
  .issue_b_id  (issue_b_id),
  .idle        (idle),
  .live_v      (live_v),
  .parked_v    (parked_v)
);

// File: tb/sim_warp_dual_issue.sv
module sim_warp_dual_issue;

  localparam int N  = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          launch_en = 1'b0, retire_en = 1'b0, wake_en = 1'b0;
  logic [IW-1:0] launch_id = '0, retire_id = '0, wake_id = '0;
  logic [N-1:0]  next_long = '0;
  logic          issue_a_vld, issue_b_vld, idle;
  logic [IW-1:0] issue_a_id, issue_b_id;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R4";

  always #5 clk = ~clk;

  warp_dual_issue #(.NUM_WARPS(N)) u0 (
    .clk, .rst, .launch_en, .launch_id, .retire_en, .retire_id,
    .wake_en, .wake_id, .next_long, .issue_a_vld, .issue_a_id,
    .issue_b_vld, .issue_b_id, .idle
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model built from the requirements ----------
  logic [N-1:0] m_live = '0, m_park = '0;
  int  m_pa = 0, m_pb = N / 2;
  bit  e_va = 0, e_vb = 0;
  int  e_ia = 0, e_ib = 0;

  always @(posedge clk) begin
    logic [N-1:0] rdy, nl, np;
    int a, b;
    if (rst) begin
      m_live = '0; m_park = '0; m_pa = 0; m_pb = N / 2;
      e_va = 0; e_vb = 0;
    end else begin
      rdy = m_live & ~m_park;
      if (retire_en) rdy[retire_id] = 1'b0;
      a = -1; b = -1;
      for (int i = 0; i < N; i++) if (a < 0 && rdy[(m_pa + i) % N]) a = (m_pa + i) % N;
      if (a >= 0)
        for (int i = 0; i < N; i++)
          if (b < 0 && rdy[(m_pb + i) % N] && ((m_pb + i) % N) != a) b = (m_pb + i) % N;
      e_va = (a >= 0); e_ia = a;
      e_vb = (b >= 0); e_ib = b;
      nl = m_live; np = m_park;
      if (wake_en) np[wake_id] = 1'b0;
      if (a >= 0) begin m_pa = (a + 1) % N; if (next_long[a]) np[a] = 1'b1; end
      if (b >= 0) begin m_pb = (b + 1) % N; if (next_long[b]) np[b] = 1'b1; end
      if (launch_en && !m_live[launch_id]) begin nl[launch_id] = 1'b1; np[launch_id] = 1'b0; end
      if (retire_en && m_live[retire_id]) begin nl[retire_id] = 1'b0; np[retire_id] = 1'b0; end
      m_live = nl; m_park = np;
    end
  end

  // cycle-by-cycle comparison against the model (R4, R5, R11 and others)
  always @(negedge clk) begin
    if (!rst) begin
      chk(issue_a_vld == e_va, cur_req, "port A valid", issue_a_vld, e_va);
      if (e_va) chk(issue_a_id == IW'(e_ia), cur_req, "port A warp", issue_a_id, e_ia);
      chk(issue_b_vld == e_vb, cur_req, "port B valid", issue_b_vld, e_vb);
      if (e_vb) chk(issue_b_id == IW'(e_ib), cur_req, "port B warp", issue_b_id, e_ib);
      chk(idle == (m_live == '0), "R9", "idle", idle, (m_live == '0));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(); @(negedge clk); endtask

  task automatic do_launch(input int s);
    launch_en = 1'b1; launch_id = IW'(s); tick(); launch_en = 1'b0;
  endtask

  task automatic do_retire(input int s);
    retire_en = 1'b1; retire_id = IW'(s); tick(); retire_en = 1'b0;
  endtask

  task automatic do_wake(input int s);
    wake_en = 1'b1; wake_id = IW'(s); tick(); wake_en = 1'b0;
  endtask

  function automatic bit saw(input int w);
    return (issue_a_vld && issue_a_id == IW'(w)) || (issue_b_vld && issue_b_id == IW'(w));
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    cur_req = "R1";
    rst = 1'b1; tick(); tick();
    chk(idle == 1'b1, "R1", "idle in reset", idle, 1);
    chk(!issue_a_vld && !issue_b_vld, "R1", "no issue in reset", issue_a_vld, 0);
    rst = 1'b0; tick();
    chk(idle == 1'b1, "R1", "idle after reset", idle, 1);
  endtask

  task automatic t_single();
    cur_req = "R2";
    launch_en = 1'b1; launch_id = 4'd3; tick(); launch_en = 1'b0;
    chk(idle == 1'b0, "R9", "idle drops after launch", idle, 0);
    chk(issue_a_vld == 1'b0, "R11", "no issue one edge after launch", issue_a_vld, 0);
    tick();
    chk(issue_a_vld && issue_a_id == 4'd3, "R2", "first issue of warp 3", issue_a_id, 3);
    cur_req = "R5";
    for (int i = 0; i < 5; i++) begin
      chk(!issue_b_vld, "R5", "port B silent with one ready warp", issue_b_vld, 0);
      tick();
    end
  endtask

  task automatic t_fill_fair();
    int cnt [N];
    bit dual = 0;
    cur_req = "R4";
    for (int s = 0; s < 8; s++) if (s != 3) do_launch(s);
    tick();
    foreach (cnt[i]) cnt[i] = 0;
    cur_req = "R10";
    for (int c = 0; c < N; c++) begin
      if (issue_a_vld) cnt[issue_a_id]++;
      if (issue_b_vld) cnt[issue_b_id]++;
      if (issue_a_vld && issue_b_vld) dual = 1;
      tick();
    end
    for (int s = 0; s < 8; s++)
      chk(cnt[s] > 0, "R10", $sformatf("warp %0d issued in window", s), cnt[s], 1);
    chk(dual, "R5", "both ports issue with many ready warps", dual, 1);
  endtask

  task automatic t_long_wake();
    bit hit;
    cur_req = "R6";
    next_long[5] = 1'b1;
    for (int c = 0; c < 10; c++) tick();
    next_long[5] = 1'b0;
    tick();
    hit = 0;
    for (int c = 0; c < 10; c++) begin hit |= saw(5); tick(); end
    chk(!hit, "R6", "parked warp 5 not issued", hit, 0);
    cur_req = "R8";
    do_launch(5);                      // launch to a live slot: no effect
    hit = 0;
    for (int c = 0; c < 6; c++) begin hit |= saw(5); tick(); end
    chk(!hit, "R8", "launch to live slot keeps park", hit, 0);
    cur_req = "R7";
    do_wake(6);                        // warp 6 not parked: no effect
    do_wake(5);
    hit = 0;
    for (int c = 0; c < 8; c++) begin hit |= saw(5); tick(); end
    chk(hit, "R7", "woken warp 5 issues again", hit, 1);
  endtask

  task automatic t_retire();
    bit hit;
    cur_req = "R8";
    do_retire(12);                     // free slot: no effect
    do_retire(2);
    tick();
    hit = 0;
    for (int c = 0; c < 8; c++) begin hit |= saw(2); tick(); end
    chk(!hit, "R8", "retired warp 2 not issued", hit, 0);
    cur_req = "R3";
    for (int s = 0; s < 8; s++) if (s != 2) do_retire(s);
    tick();
    chk(idle == 1'b1, "R9", "idle after all retired", idle, 1);
    chk(!issue_a_vld, "R3", "no issue with empty pool", issue_a_vld, 0);
    do_retire(4);
    chk(idle == 1'b1, "R8", "retire of free slot keeps idle", idle, 1);
  endtask

  task automatic t_midreset();
    cur_req = "R2";
    do_launch(9); do_launch(10); tick(); tick();
    cur_req = "R1";
    rst = 1'b1; tick();
    chk(idle == 1'b1, "R1", "idle after mid-run reset", idle, 1);
    chk(!issue_a_vld && !issue_b_vld, "R1", "no issue after mid-run reset", issue_b_vld, 0);
    rst = 1'b0; tick();
    do_launch(0); tick(); tick();
  endtask

  initial begin
    t_reset();
    t_single();
    t_fill_fair();
    t_long_wake();
    t_retire();
    t_midreset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule